// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block guards a data word with a positional Hamming code and one whole-word parity bit. The encoder side takes a 64-bit word and builds a 72-bit codeword. The decoder side takes a 72-bit codeword, which may have been damaged in storage or in transit. It returns the data, repaired when exactly one bit is wrong. It raises one of two flags: the damage was corrected, or the damage cannot be corrected.

The two paths are independent. Each has one register stage, so every result appears one clock after its input. A typical user encodes on the write path of a memory and decodes on the read path. The data width is a parameter. The number of positional check bits is derived from it as the smallest count that can address every codeword position.

Top module: `ecc_secded_codec`

## Requirements
- R1: Codeword bit p, for p from 1 to 71, is Hamming position p, and bit 0 holds the whole-word parity. Positions that are powers of two (1, 2, 4, 8, 16, 32, 64) hold check bits. Data bit i sits at the i-th position, in ascending order, that is not a power of two, so data bit 0 is at position 3 and data bit 63 is at position 71.
- R2: The check bit at position 2^k makes the XOR of every position whose index has bit k set (positions 1 to 71) equal to zero.
- R3: Codeword bit 0 makes the XOR of all 72 codeword bits equal to zero.
- R4: Every output is registered: a result appears at the first rising edge after its input is applied. A synchronous active-high reset clears all outputs to zero.
- R5: A codeword received without damage returns its data unchanged, with both flags low.
- R6: A codeword with exactly one flipped bit among positions 1 to 71 returns the original data, with the corrected flag high and the uncorrectable flag low.
- R7: A codeword whose only flipped bit is bit 0 returns the original data, with the corrected flag high and the uncorrectable flag low.
- R8: A codeword with two flipped bits raises the uncorrectable flag with the corrected flag low, and returns the data field exactly as received.
- R9: A nonzero syndrome above 71 combined with odd overall parity is reported as uncorrectable, and the data field passes through as received.
- R10: The corrected flag and the uncorrectable flag are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enc_data_i | input | 64 | Word to be encoded |
| enc_cw_o | output | 72 | Registered codeword for enc_data_i |
| dec_cw_i | input | 72 | Codeword to be checked and repaired |
| dec_data_o | output | 64 | Registered data, corrected when possible |
| dec_sec_o | output | 1 | Registered flag: a single error was corrected |
| dec_ded_o | output | 1 | Registered flag: the error cannot be corrected |

## Verification
The bench builds the codec with its default 64-bit data width. That width derives 7 positional check bits and 71 used positions, which leaves the syndrome values 72 to 127 unused. Those unused values are the only way to exercise the out-of-range rule: three flips (positions 64, 8 and the parity bit) produce syndrome 72 with odd parity. At this width a single-flip sweep also covers every position of the codeword, including the last data position, each check-bit position and the parity bit.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int unsigned DEF_DATA_W = 64;

    // Smallest positional check-bit count r with 2^r >= data + r + 1
    function automatic int unsigned chk_bits(input int unsigned dw);
        int unsigned r;
        r = 1;
        for (int i = 0; i < 31; i++) begin
            if ((32'd1 << r) < dw + r + 1) r = r + 1;
        end
        return r;
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_PARITY = 2'd1,
        ERR_SINGLE = 2'd2,
        ERR_DOUBLE = 2'd3
    } err_kind_e;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned PAR_W = chk_bits(DATA_W),
    localparam int unsigned CW_W  = DATA_W + PAR_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:0]  placed;
    logic [PAR_W-1:0] chk;

    // Scatter data into the non-power-of-two positions
    always_comb begin
        int unsigned d;
        d = 0;
        placed = '0;
        for (int unsigned p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                placed[p] = data_i[d];
                d = d + 1;
            end
        end
    end

    // One even-parity tree per positional check bit
    for (genvar k = 0; k < PAR_W; k++) begin : g_chk
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int unsigned p = 1; p < CW_W; p++) begin
                if (p[k]) acc = acc ^ placed[p];
            end
        end
        assign chk[k] = acc;
    end

    always_comb begin
        cw_o = placed;
        for (int unsigned k = 0; k < PAR_W; k++) begin
            cw_o[32'd1 << k] = chk[k];
        end
        cw_o[0] = ^cw_o[CW_W-1:1];
    end

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned PAR_W = chk_bits(DATA_W),
    localparam int unsigned CW_W  = DATA_W + PAR_W + 1
) (
    input  logic [CW_W-1:0]  cw_i,
    output logic [PAR_W-1:0] syn_o,
    output logic             odd_o
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int unsigned p = 1; p < CW_W; p++) begin
                if (p[k]) acc = acc ^ cw_i[p];
            end
        end
        assign syn_o[k] = acc;
    end

    assign odd_o = ^cw_i;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned PAR_W = chk_bits(DATA_W),
    localparam int unsigned CW_W  = DATA_W + PAR_W + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output err_kind_e         kind_o
);

    localparam logic [PAR_W-1:0] LAST_POS = PAR_W'(CW_W - 1);

    logic [PAR_W-1:0] syn;
    logic             odd;
    logic             in_range;
    logic [CW_W-1:0]  fixed;

    ecc_syndrome #(.DATA_W(DATA_W)) syn_i (
        .cw_i  (cw_i),
        .syn_o (syn),
        .odd_o (odd)
    );

    assign in_range = (syn <= LAST_POS);

    always_comb begin
        if (syn == '0) begin
            kind_o = odd ? ERR_PARITY : ERR_NONE;
        end else if (odd && in_range) begin
            kind_o = ERR_SINGLE;
        end else begin
            kind_o = ERR_DOUBLE;
        end
    end

    always_comb begin
        fixed = cw_i;
        if (kind_o == ERR_SINGLE) fixed[syn] = ~cw_i[syn];
    end

    always_comb begin
        int unsigned d;
        d = 0;
        data_o = '0;
        for (int unsigned p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                data_o[d] = fixed[p];
                d = d + 1;
            end
        end
    end

endmodule

// File: rtl/ecc_secded_codec.sv
module ecc_secded_codec
    import ecc_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned CW_W  = DATA_W + chk_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W-1:0]   enc_cw_o,
    input  logic [CW_W-1:0]   dec_cw_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_sec_o,
    output logic              dec_ded_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sec;
        logic              ded;
    } dec_res_t;

    logic [CW_W-1:0]   enc_cw_d;
    logic [DATA_W-1:0] dec_data_d;
    err_kind_e         dec_kind;
    dec_res_t          res_d, res_q;

    ecc_enc #(.DATA_W(DATA_W)) enc_i (
        .data_i (enc_data_i),
        .cw_o   (enc_cw_d)
    );

    ecc_dec #(.DATA_W(DATA_W)) dec_i (
        .cw_i   (dec_cw_i),
        .data_o (dec_data_d),
        .kind_o (dec_kind)
    );

    always_comb begin
        res_d.data = dec_data_d;
        res_d.sec  = (dec_kind == ERR_SINGLE) || (dec_kind == ERR_PARITY);
        res_d.ded  = (dec_kind == ERR_DOUBLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_cw_o <= '0;
            res_q    <= '0;
        end else begin
            enc_cw_o <= enc_cw_d;
            res_q    <= res_d;
        end
    end

    assign dec_data_o = res_q.data;
    assign dec_sec_o  = res_q.sec;
    assign dec_ded_o  = res_q.ded;

    // Data field of the received codeword, taken without any repair
    logic [DATA_W-1:0] raw_data;
    logic [DATA_W-1:0] enc_field;
    always_comb begin
        int unsigned d;
        d = 0;
        raw_data  = '0;
        enc_field = '0;
        for (int unsigned p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                raw_data[d]  = dec_cw_i[p];
                enc_field[d] = enc_cw_o[p];
                d = d + 1;
            end
        end
    end

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(dec_sec_o && dec_ded_o));

    assert_enc_even_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (^enc_cw_o) == 1'b0);

    assert_enc_field_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> enc_field == $past(enc_data_i));

    assert_ded_passthru_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dec_ded_o) |-> dec_data_o == $past(raw_data));

    assert_sec_onebit_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dec_sec_o) |-> $countones(dec_data_o ^ $past(raw_data)) <= 1);

    assert_clean_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !dec_sec_o && !dec_ded_o) |-> dec_data_o == $past(raw_data));

endmodule

// File: tb/ecc_secded_codec_tb_top.sv
module ecc_secded_codec_tb_top;
    import ecc_pkg::*;

    localparam int unsigned DW   = DEF_DATA_W;
    localparam int unsigned CW   = DW + chk_bits(DW) + 1;
    localparam int unsigned NVEC = 10;
    localparam logic [6:0]  NO   = 7'd127;

    // {data, flip a, flip b, flip c, exp sec, exp ded}
    localparam logic [86:0] VEC [0:NVEC-1] = '{
        {64'h0000_0000_0000_0000, NO,    NO,    NO,    1'b0, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, NO,    NO,    NO,    1'b0, 1'b0},
        {64'hA5A5_A5A5_A5A5_A5A5, 7'd3,  NO,    NO,    1'b1, 1'b0},
        {64'h0123_4567_89AB_CDEF, 7'd64, NO,    NO,    1'b1, 1'b0},
        {64'hFEDC_BA98_7654_3210, 7'd0,  NO,    NO,    1'b1, 1'b0},
        {64'hDEAD_BEEF_CAFE_F00D, 7'd5,  7'd9,  NO,    1'b0, 1'b1},
        {64'h8000_0000_0000_0001, 7'd71, 7'd1,  NO,    1'b0, 1'b1},
        {64'h5555_5555_5555_5555, 7'd64, 7'd8,  7'd0,  1'b0, 1'b1},
        {64'h3333_3333_3333_3333, 7'd0,  7'd7,  NO,    1'b0, 1'b1},
        {64'hAAAA_AAAA_AAAA_AAAA, 7'd71, NO,    NO,    1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] enc_data_i = '0;
    logic [CW-1:0] enc_cw_o;
    logic [CW-1:0] dec_cw_i = '0;
    logic [DW-1:0] dec_data_o;
    logic          dec_sec_o;
    logic          dec_ded_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ecc_secded_codec #(.DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .enc_data_i (enc_data_i),
        .enc_cw_o   (enc_cw_o),
        .dec_cw_i   (dec_cw_i),
        .dec_data_o (dec_data_o),
        .dec_sec_o  (dec_sec_o),
        .dec_ded_o  (dec_ded_o)
    );

    // Model of R1/R2/R3
    function automatic logic [CW-1:0] model_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int unsigned   j;
        c = '0;
        j = 0;
        for (int unsigned p = 3; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j = j + 1;
            end
        end
        for (int unsigned k = 0; (32'd1 << k) < CW; k++) begin
            logic s;
            s = 1'b0;
            for (int unsigned p = 1; p < CW; p++) if ((p >> k) & 1) s = s ^ c[p];
            c[32'd1 << k] = s;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] model_field(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        int unsigned   j;
        d = '0;
        j = 0;
        for (int unsigned p = 3; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = c[p];
                j = j + 1;
            end
        end
        return d;
    endfunction

    function automatic logic [CW-1:0] fmask(input logic [6:0] pos);
        logic [CW-1:0] m;
        m = '0;
        if (pos != NO) m[pos] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] cw;
        logic [CW-1:0] bad;
        logic [DW-1:0] pat;

        repeat (3) @(negedge clk);
        // R4 reset state
        check("R4 reset enc", 128'(enc_cw_o), 128'(0));
        check("R4 reset dec", {dec_data_o, dec_sec_o, dec_ded_o}, 128'(0));
        rst = 1'b0;

        // R4 latency: output holds until the next edge
        enc_data_i = 64'h1111_2222_3333_4444;
        #1;
        check("R4 no early update", 128'(enc_cw_o), 128'(0));
        step();
        check("R4 one cycle enc", 128'(enc_cw_o), 128'(model_enc(64'h1111_2222_3333_4444)));

        // Table walk: R1 R2 R3 encode, R5..R9 decode
        for (int i = 0; i < NVEC; i++) begin
            logic [63:0] vd;
            logic [6:0]  fa, fb, fc;
            logic        es, ed;
            logic [DW-1:0] exp_d;
            {vd, fa, fb, fc, es, ed} = VEC[i];
            enc_data_i = vd;
            step();
            cw = model_enc(vd);
            check("R1 R2 R3 encode", 128'(enc_cw_o), 128'(cw));
            bad = cw ^ fmask(fa) ^ fmask(fb) ^ fmask(fc);
            dec_cw_i = bad;
            step();
            exp_d = ed ? model_field(bad) : vd;
            check(ed ? "R8 R9 uncorrectable" : (es ? "R6 R7 corrected" : "R5 clean"),
                  {dec_data_o, dec_sec_o, dec_ded_o}, {exp_d, es, ed});
        end

        // R6 R7: single flip at every codeword bit
        pat = 64'hC3A5_0F96_7E18_2B4D;
        cw  = model_enc(pat);
        for (int p = 0; p < int'(CW); p++) begin
            dec_cw_i = cw ^ fmask(7'(p));
            step();
            check(p == 0 ? "R7 parity bit flip" : "R6 single flip sweep",
                  {dec_data_o, dec_sec_o, dec_ded_o}, {pat, 1'b1, 1'b0});
        end

        // R10: flags stay exclusive across a double flip sweep
        for (int p = 1; p < int'(CW); p++) begin
            dec_cw_i = cw ^ fmask(7'(p)) ^ fmask(7'((p % (CW - 1)) + 1));
            step();
            check("R10 R8 double sweep", {dec_sec_o, dec_ded_o}, {1'b0, 1'b1});
        end

        // R4: reset during operation clears registered outputs
        enc_data_i = 64'hFFFF_0000_FFFF_0000;
        dec_cw_i   = cw ^ fmask(7'd3) ^ fmask(7'd6);
        rst = 1'b1;
        step();
        check("R4 mid reset", {dec_data_o, dec_sec_o, dec_ded_o}, 128'(0));
        check("R4 mid reset enc", 128'(enc_cw_o), 128'(0));
        rst = 1'b0;
        step();
        check("R4 after reset", {dec_data_o, dec_sec_o, dec_ded_o},
              {model_field(cw ^ fmask(7'd3) ^ fmask(7'd6)), 1'b0, 1'b1});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule